// File: doc/BRIEF.md
# Reset Start-up Sequencer with Cause Flags

This block sits between the reset sources of a small microcontroller and its core. It holds the core in reset after power-on, a brown-out, an external pin reset or a watchdog time-out. It releases the core after a start-up delay. The delay is built from two stages: a power-up timer whose length is a cycle-count parameter, then an oscillator start-up timer that counts oscillator clocks. Each stage is switched on or off by the reset source, by the oscillator mode (crystal-type or RC) and by a power-up-timer configuration bit. The block clock stands for the oscillator clock.

Beside the sequencer, four status flags record the cause of the last reset. Two sleep-state flags mark a watchdog event and whether the part was asleep. Two power-control flags mark power-on and brown-out, and software can write them. The sequencer also handles entry into sleep and wake-up from sleep. A wake-up in crystal mode applies only the oscillator delay.

Top module: `startup_reset_seq`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is high. After it falls, `core_rst` stays high for PWRT_CYCLES clock cycles, then for OST_CYCLES more cycles, and then falls. This holds with `pwrt_disable`=0 and `osc_rc_mode`=0.
- R2: When `pwrt_disable`=1, the power-up stage is skipped after power-on.
- R3: When `osc_rc_mode`=1, the oscillator stage is skipped after power-on and after the power-up stage. With both stages skipped, `core_rst` is low on the first sample after the first clock edge.
- R4: A `brownout` with `bor_enable`=1 restarts the sequence. It always applies the PWRT_CYCLES stage, even when `pwrt_disable`=1. In crystal mode it then adds OST_CYCLES. When `bor_enable`=0, `brownout` has no effect on `core_rst` or on the flags.
- R5: `sleep_enter` while running enters sleep without asserting `core_rst`. A `wake_event` in sleep holds `core_rst` for OST_CYCLES cycles in crystal mode and for no cycles in RC mode.
- R6: `ext_rst_n` passes through a two-flop synchronizer. A low pin raises `core_rst` two clock edges later, whatever the timer state. The timers keep running while the pin is low. If the pin is released after the timers have expired, `core_rst` falls two edges later.
- R7: On power-on the flags read `flag_to`=1, `flag_pd`=1, `flag_por`=0 and `flag_bor`=0.
- R8: A write with `sw_wr_en`=1 loads `flag_por` from `sw_wr_data[1]`. `flag_por` is cleared only by power-on. Brown-out, watchdog and pin resets leave it unchanged.
- R9: The same write loads `flag_bor` from `sw_wr_data[0]`. An enabled brown-out clears `flag_bor`, and the brown-out wins over a write in the same cycle.
- R10: A `wdt_timeout` while running asserts `core_rst` for exactly one cycle, clears `flag_to` and leaves `flag_pd` unchanged. A `wdt_timeout` during sleep is a wake-up: it clears both `flag_to` and `flag_pd` and applies the R5 wake delay.
- R11: A pin reset while running leaves `flag_to` and `flag_pd` unchanged. A pin reset during sleep sets `flag_to`=1 and `flag_pd`=0 and ends sleep, so a later `wdt_timeout` acts as a run-time watchdog reset.
- R12: A brown-out that arrives in the middle of a delay restarts the power-up stage from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| brownout | input | 1 | Brown-out detect, active high, synchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| sleep_enter | input | 1 | Request to enter sleep |
| wake_event | input | 1 | Wake-up event while asleep |
| osc_rc_mode | input | 1 | 1 = RC oscillator, 0 = crystal-type |
| pwrt_disable | input | 1 | 1 = skip the power-up timer |
| bor_enable | input | 1 | 1 = brown-out detection active |
| sw_wr_en | input | 1 | Software write strobe for the power flags |
| sw_wr_data | input | 2 | Bit 1 = power-on flag, bit 0 = brown-out flag |
| core_rst | output | 1 | Core reset, active high |
| flag_to | output | 1 | Watchdog-event flag (0 after a watchdog event) |
| flag_pd | output | 1 | Sleep flag (0 after a sleep-related event) |
| flag_por | output | 1 | Power-on flag (0 after power-on) |
| flag_bor | output | 1 | Brown-out flag (0 after a brown-out) |

## Verification
The bench builds the block with PWRT_CYCLES=6 and OST_CYCLES=4. These short values let it sweep every combination of timer enable and oscillator mode for both power-on and brown-out. It compares the measured length of the reset with the sum of the enabled stages. Since the two stages differ in length, a wrong stage, a missing stage or a swapped order shows up as a wrong count. A watchdog reset lasts one cycle and a crystal wake-up lasts four, so the bench can tell from the reset length whether the block is still asleep.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        SQ_START = 3'd0,
        SQ_PWRT  = 3'd1,
        SQ_OST   = 3'd2,
        SQ_WDT   = 3'd3,
        SQ_RUN   = 3'd4,
        SQ_SLEEP = 3'd5
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    typedef struct packed {
        logic to;
        logic pd;
        logic por;
        logic bor;
    } cause_flags_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) chain_q <= '1;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !run)        cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = run && !clr && (cnt_q == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R1
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!run || clr) |=> (cnt_q == '0)); // R12
endmodule

// File: rtl/rstseq_flags.sv
module rstseq_flags
    import rstseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt_bor,
    input  logic evt_wdt_rst,
    input  logic evt_wdt_wake,
    input  logic evt_ext_sleep,
    input  logic sw_we,
    input  logic sw_por,
    input  logic sw_bor,
    output cause_flags_t flags
);
    cause_flags_t flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (sw_we) begin
            flags_d.por = sw_por;
            flags_d.bor = sw_bor;
        end
        if (evt_bor) flags_d.bor = 1'b0;
        if (evt_wdt_rst) flags_d.to = 1'b0;
        if (evt_wdt_wake) begin
            flags_d.to = 1'b0;
            flags_d.pd = 1'b0;
        end
        if (evt_ext_sleep) begin
            flags_d.to = 1'b1;
            flags_d.pd = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) flags_q <= '{to: 1'b1, pd: 1'b1, por: 1'b0, bor: 1'b0};
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_POR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> $stable(flags_q.por)); // R8
    AST_BOR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        evt_bor |=> !flags_q.bor); // R9
    AST_WDT_RUN_FLAGS: assert property (@(posedge clk) disable iff (rst)
        evt_wdt_rst |=> (!flags_q.to && flags_q.pd == $past(flags_q.pd))); // R10
    AST_EXT_SLEEP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        evt_ext_sleep |=> (flags_q.to && !flags_q.pd)); // R11
endmodule

// File: rtl/startup_reset_seq.sv
module startup_reset_seq
    import rstseq_pkg::*;
#(
    parameter int PWRT_CYCLES = 4096,
    parameter int OST_CYCLES  = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_pulse,
    input  logic       brownout,
    input  logic       ext_rst_n,
    input  logic       wdt_timeout,
    input  logic       sleep_enter,
    input  logic       wake_event,
    input  logic       osc_rc_mode,
    input  logic       pwrt_disable,
    input  logic       bor_enable,
    input  logic       sw_wr_en,
    input  logic [1:0] sw_wr_data,
    output logic       core_rst,
    output logic       flag_to,
    output logic       flag_pd,
    output logic       flag_por,
    output logic       flag_bor
);
    seq_regs_t    seq_d, seq_q;
    cause_flags_t flags;
    logic ext_sync, ext_low, bor_evt;
    logic pwrt_done, ost_done;
    logic evt_wdt_rst, evt_wdt_wake, evt_ext_sleep;
    logic hold_state;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk (clk),
        .rst (por_pulse),
        .din (ext_rst_n),
        .dout(ext_sync)
    );

    assign ext_low = !ext_sync;
    assign bor_evt = brownout && bor_enable;

    rstseq_delay #(.LIMIT(PWRT_CYCLES)) u_pwrt (
        .clk (clk),
        .rst (por_pulse),
        .run (seq_q.state == SQ_PWRT),
        .clr (bor_evt),
        .done(pwrt_done)
    );

    rstseq_delay #(.LIMIT(OST_CYCLES)) u_ost (
        .clk (clk),
        .rst (por_pulse),
        .run (seq_q.state == SQ_OST),
        .clr (bor_evt),
        .done(ost_done)
    );

    always_comb begin
        seq_d         = seq_q;
        evt_wdt_rst   = 1'b0;
        evt_wdt_wake  = 1'b0;
        evt_ext_sleep = 1'b0;
        if (bor_evt) begin
            seq_d.state = SQ_PWRT;
        end else begin
            unique case (seq_q.state)
                SQ_START: begin
                    if (!pwrt_disable)     seq_d.state = SQ_PWRT;
                    else if (!osc_rc_mode) seq_d.state = SQ_OST;
                    else                   seq_d.state = SQ_RUN;
                end
                SQ_PWRT: begin
                    if (pwrt_done) seq_d.state = osc_rc_mode ? SQ_RUN : SQ_OST;
                end
                SQ_OST: begin
                    if (ost_done) seq_d.state = SQ_RUN;
                end
                SQ_WDT: seq_d.state = SQ_RUN;
                SQ_RUN: begin
                    if (!ext_low) begin
                        if (wdt_timeout) begin
                            seq_d.state = SQ_WDT;
                            evt_wdt_rst = 1'b1;
                        end else if (sleep_enter) begin
                            seq_d.state = SQ_SLEEP;
                        end
                    end
                end
                SQ_SLEEP: begin
                    if (ext_low) begin
                        seq_d.state   = SQ_RUN;
                        evt_ext_sleep = 1'b1;
                    end else if (wdt_timeout || wake_event) begin
                        seq_d.state  = osc_rc_mode ? SQ_RUN : SQ_OST;
                        evt_wdt_wake = wdt_timeout;
                    end
                end
                default: seq_d.state = SQ_START;
            endcase
        end
    end

    always_ff @(posedge clk or posedge por_pulse) begin
        if (por_pulse) seq_q <= '{state: SQ_START};
        else           seq_q <= seq_d;
    end

    rstseq_flags u_flags (
        .clk          (clk),
        .rst          (por_pulse),
        .evt_bor      (bor_evt),
        .evt_wdt_rst  (evt_wdt_rst),
        .evt_wdt_wake (evt_wdt_wake),
        .evt_ext_sleep(evt_ext_sleep),
        .sw_we        (sw_wr_en),
        .sw_por       (sw_wr_data[1]),
        .sw_bor       (sw_wr_data[0]),
        .flags        (flags)
    );

    assign hold_state = (seq_q.state == SQ_START) || (seq_q.state == SQ_PWRT) ||
                        (seq_q.state == SQ_OST)   || (seq_q.state == SQ_WDT);
    assign core_rst   = por_pulse || hold_state || ext_low;
    assign flag_to    = flags.to;
    assign flag_pd    = flags.pd;
    assign flag_por   = flags.por;
    assign flag_bor   = flags.bor;

    AST_OST_ORDER: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_q.state == SQ_OST && $past(seq_q.state) != SQ_OST) |->
        ($past(seq_q.state) == SQ_PWRT || $past(seq_q.state) == SQ_SLEEP ||
         ($past(seq_q.state) == SQ_START && $past(pwrt_disable)))); // R1
    AST_RC_NO_OST: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_q.state == SQ_OST && $past(seq_q.state) != SQ_OST) |->
        !$past(osc_rc_mode)); // R3
    AST_BOR_RESTART: assert property (@(posedge clk) disable iff (por_pulse)
        bor_evt |=> (seq_q.state == SQ_PWRT && core_rst)); // R12
    AST_SLEEP_NO_RST: assert property (@(posedge clk) disable iff (por_pulse)
        (seq_q.state == SQ_SLEEP && ext_sync) |-> !core_rst); // R5
endmodule

// File: tb/startup_reset_seq_bench.sv
module startup_reset_seq_bench;
    localparam int N = 6;
    localparam int M = 4;

    logic clk = 1'b0;
    logic por_pulse = 1'b1, brownout = 1'b0, ext_rst_n = 1'b1;
    logic wdt_timeout = 1'b0, sleep_enter = 1'b0, wake_event = 1'b0;
    logic osc_rc_mode = 1'b0, pwrt_disable = 1'b0, bor_enable = 1'b1;
    logic sw_wr_en = 1'b0;
    logic [1:0] sw_wr_data = 2'b00;
    logic core_rst, flag_to, flag_pd, flag_por, flag_bor;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    startup_reset_seq #(.PWRT_CYCLES(N), .OST_CYCLES(M)) u_startup_reset_seq (
        .clk(clk), .por_pulse(por_pulse), .brownout(brownout), .ext_rst_n(ext_rst_n),
        .wdt_timeout(wdt_timeout), .sleep_enter(sleep_enter), .wake_event(wake_event),
        .osc_rc_mode(osc_rc_mode), .pwrt_disable(pwrt_disable), .bor_enable(bor_enable),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .core_rst(core_rst),
        .flag_to(flag_to), .flag_pd(flag_pd), .flag_por(flag_por), .flag_bor(flag_bor)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    // Counts samples with core_rst high; pulse inputs drop after the first edge.
    task automatic measure(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk);
            @(negedge clk);
            brownout = 1'b0; wdt_timeout = 1'b0;
            sleep_enter = 1'b0; wake_event = 1'b0; sw_wr_en = 1'b0;
            if (!core_rst) break;
            n++;
        end
    endtask

    task automatic power_on(input logic pd, input logic rc, output int n);
        @(negedge clk);
        pwrt_disable = pd; osc_rc_mode = rc; por_pulse = 1'b1;
        step(3);
        por_pulse = 1'b0;
        measure(n);
    endtask

    task automatic sw_write(input logic [1:0] v);
        sw_wr_data = v; sw_wr_en = 1'b1;
        step(1);
        sw_wr_en = 1'b0;
        step(1);
    endtask

    task automatic run_tests;
        int n;
        step(2);
        check("R1 rst during por", core_rst, 1);
        check("R7 to", flag_to, 1);
        check("R7 pd", flag_pd, 1);
        check("R7 por", flag_por, 0);
        check("R7 bor", flag_bor, 0);

        for (int pd = 0; pd < 2; pd++)
            for (int rc = 0; rc < 2; rc++) begin
                power_on(pd[0], rc[0], n);
                check(pd == 0 && rc == 0 ? "R1 por delay" : (pd == 1 ? "R2 por delay" : "R3 por delay"),
                      n, (pd == 0 ? N : 0) + (rc == 0 ? M : 0));
            end

        sw_write(2'b11);
        check("R8 por written", flag_por, 1);
        check("R9 bor written", flag_bor, 1);

        for (int pd = 0; pd < 2; pd++)
            for (int rc = 0; rc < 2; rc++) begin
                pwrt_disable = pd[0]; osc_rc_mode = rc[0];
                brownout = 1'b1;
                measure(n);
                check("R4 brownout delay", n, N + (rc == 0 ? M : 0));
            end
        check("R9 bor cleared", flag_bor, 0);
        check("R8 por kept on brownout", flag_por, 1);

        pwrt_disable = 1'b0; osc_rc_mode = 1'b0;
        sw_write(2'b11);
        bor_enable = 1'b0;
        brownout = 1'b1;
        measure(n);
        check("R4 disabled brownout no reset", n, 0);
        check("R9 disabled brownout keeps bor", flag_bor, 1);
        bor_enable = 1'b1;

        // sw write and brownout together: brownout wins
        sw_wr_data = 2'b11; sw_wr_en = 1'b1; brownout = 1'b1;
        measure(n);
        check("R9 brownout beats write", flag_bor, 0);

        brownout = 1'b1;
        step(1);
        brownout = 1'b0;
        step(3);
        brownout = 1'b1;
        measure(n);
        check("R12 restart mid-sequence", n, N + M);

        wdt_timeout = 1'b1;
        measure(n);
        check("R10 wdt run pulse", n, 1);
        check("R10 wdt run to", flag_to, 0);
        check("R10 wdt run pd", flag_pd, 1);
        check("R8 por kept on wdt", flag_por, 1);

        sleep_enter = 1'b1;
        measure(n);
        check("R5 sleep entry no reset", n, 0);
        wake_event = 1'b1;
        measure(n);
        check("R5 crystal wake delay", n, M);
        check("R5 wake keeps pd", flag_pd, 1);

        osc_rc_mode = 1'b1;
        sleep_enter = 1'b1;
        measure(n);
        wake_event = 1'b1;
        measure(n);
        check("R5 rc wake delay", n, 0);
        osc_rc_mode = 1'b0;

        sleep_enter = 1'b1;
        measure(n);
        wdt_timeout = 1'b1;
        measure(n);
        check("R10 wdt wake delay", n, M);
        check("R10 wdt wake to", flag_to, 0);
        check("R10 wdt wake pd", flag_pd, 0);

        ext_rst_n = 1'b0;
        step(1);
        check("R6 sync first stage", core_rst, 0);
        step(1);
        check("R6 pin reset asserted", core_rst, 1);
        step(3);
        check("R11 run pin keeps to", flag_to, 0);
        check("R11 run pin keeps pd", flag_pd, 0);
        ext_rst_n = 1'b1;
        step(1);
        check("R6 release sync", core_rst, 1);
        step(1);
        check("R6 release", core_rst, 0);

        sw_write(2'b11);
        sleep_enter = 1'b1;
        measure(n);
        ext_rst_n = 1'b0;
        step(4);
        check("R11 sleep pin to", flag_to, 1);
        check("R11 sleep pin pd", flag_pd, 0);
        ext_rst_n = 1'b1;
        step(3);
        check("R11 sleep pin released", core_rst, 0);
        wdt_timeout = 1'b1;
        measure(n);
        check("R11 sleep exited", n, 1);

        @(negedge clk);
        ext_rst_n = 1'b0; pwrt_disable = 1'b0; osc_rc_mode = 1'b0; por_pulse = 1'b1;
        step(2);
        por_pulse = 1'b0;
        step(N + M + 6);
        check("R6 pin holds after timers", core_rst, 1);
        check("R8 por cleared by power-on", flag_por, 0);
        ext_rst_n = 1'b1;
        step(1);
        check("R6 release after timers sync", core_rst, 1);
        step(1);
        check("R6 immediate start", core_rst, 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule